// File: doc/BRIEF.md
# RTC Register Access Engine

This block is the byte-level register side of a real-time-clock target on a two-wire serial bus. A bus front end, already decoded, hands it four kinds of event: a write transfer opening, a read transfer opening, a received data byte, and a request for the next byte to send. Behind those events sits a 64-byte register space addressed by a 6-bit auto-incrementing pointer. Entries 0 to 6 are a shadow of the live time and date, entry 7 is a control byte with filtered writes, and entries 8 to 63 are plain RAM.

The first byte of each write transfer is taken as the register address. Later bytes either go to RAM or the control byte, or, for entries 0 to 6, are passed on to an external timekeeper as a one-cycle load strobe. The shadow is refreshed from the live time whenever a read transfer opens and whenever the pointer wraps from 63 to 0, so a burst read that runs through the whole space sees a fresh, coherent time.

The transfer control is a two-state machine. State `XS_DATA` treats bytes as data. State `XS_ADDR` expects an address byte. Transition WRITE_OPEN goes from either state to `XS_ADDR` on a write-transfer start. Transition ADDR_TAKEN goes from `XS_ADDR` to `XS_DATA` when a byte is received. All other events leave the state unchanged. A read-transfer start does not change the state.

Top module: `rtc_regfile_engine`

## Requirements
- R1: After reset all 64 entries read as zero, the pointer is zero and no address byte is expected, so a byte received before any write start is treated as data at entry 0.
- R2: The first byte after a write start loads its low 6 bits into the pointer (for example 0xC8 selects entry 8). It writes no entry and raises no timekeeper load.
- R3: A read request returns the entry at the pointer on `rd_data`, registered and valid one cycle later, and then advances the pointer by one.
- R4: A data byte aimed at entries 8 to 63 is stored there, and the pointer then advances by one.
- R5: A data byte aimed at entries 0 to 6 raises `tk_load` in that same cycle, with `tk_field` equal to the entry index and `tk_data` equal to the byte. The shadow entry is left unchanged and the pointer advances.
- R6: A read start copies `live_time` byte i (bits 8i+7 to 8i) into shadow entry i for i from 0 to 6.
- R7: When an increment takes the pointer from 63 to 0, the shadow is reloaded from `live_time`. A read of entry 63 still returns the old content of entry 63.
- R8: A write to entry 7 is masked with 0xB3, so bits 6, 3 and 2 of entry 7 always read back as zero.
- R9: Bit 5 of entry 7 is a clear-only stop flag. Writing 1 keeps its current value and writing 0 clears it, so a 0xFF write reads back as 0x93 while the flag is clear.
- R10: When several events arrive in the same cycle, only the highest-priority one acts. The order from highest to lowest is read start, write start, received byte, read request.
- R11: `rd_valid` is high exactly in the cycle after an accepted read request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wr_start | input | 1 | Write transfer opened |
| ev_rd_start | input | 1 | Read transfer opened |
| ev_wr_byte | input | 1 | Byte received, value on wr_data |
| wr_data | input | 8 | Received byte |
| ev_rd_req | input | 1 | Next byte requested for sending |
| live_time | input | 56 | Live time/date, byte i for shadow entry i |
| rd_data | output | 8 | Byte returned for a read request |
| rd_valid | output | 1 | rd_data valid (one cycle after request) |
| tk_load | output | 1 | One-cycle load strobe to the timekeeper |
| tk_field | output | 3 | Time field index of the load |
| tk_data | output | 8 | Value of the load |

## Verification
A single increment can do two things in the same cycle: a read or write of entry 63, and the wraparound snapshot of live time into the shadow. The bench places the pointer at 63, writes a marker byte there, changes `live_time`, and then reads entry 63 followed by entry 0. The first read must return the marker, which shows the read came before the refresh. The second read must return the new live value, which shows the snapshot was taken at the wrap and not at an earlier read start.

// File: rtl/rtc_reg_pkg.sv
package rtc_reg_pkg;
    localparam int BYTE_W      = 8;
    localparam int TIME_REGS   = 7;
    localparam int FIELD_W     = 3;
    localparam int CTRL_ADDR   = 7;
    localparam int STOP_BIT    = 5;
    localparam logic [BYTE_W-1:0] CTRL_KEEP_MASK = 8'hB3;

    typedef enum logic [0:0] {
        XS_DATA = 1'b0,
        XS_ADDR = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/rtc_xfer_fsm.sv
module rtc_xfer_fsm
    import rtc_reg_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_wr_start,
    input  logic                ev_rd_start,
    input  logic                ev_wr_byte,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                ev_rd_req,
    output logic [PTR_W-1:0]    ptr,
    output logic                snap,
    output logic                store_we,
    output logic                rd_en,
    output logic                tk_load,
    output logic [FIELD_W-1:0]  tk_field,
    output logic [BYTE_W-1:0]   tk_data
);
    localparam logic [PTR_W-1:0] PTR_LAST = '1;

    xfer_state_e state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic do_rs, do_ws, do_wb, do_rr;
    logic addr_take, data_wr, bump, wrap, in_time;

    // event priority: read start > write start > byte > read request
    assign do_rs = ev_rd_start;
    assign do_ws = ev_wr_start & ~ev_rd_start;
    assign do_wb = ev_wr_byte & ~ev_rd_start & ~ev_wr_start;
    assign do_rr = ev_rd_req & ~ev_rd_start & ~ev_wr_start & ~ev_wr_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_DATA;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        addr_take = 1'b0;
        data_wr   = 1'b0;
        unique case (state_q)
            XS_ADDR: begin
                if (do_ws) begin
                    state_d = XS_ADDR;
                end else if (do_wb) begin
                    addr_take = 1'b1;
                    state_d   = XS_DATA;
                end
            end
            XS_DATA: begin
                if (do_ws) begin
                    state_d = XS_ADDR;
                end else if (do_wb) begin
                    data_wr = 1'b1;
                end
            end
            default: state_d = XS_DATA;
        endcase

        bump    = data_wr | do_rr;
        wrap    = bump & (ptr_q == PTR_LAST);
        in_time = (ptr_q < PTR_W'(TIME_REGS));

        if (addr_take)  ptr_d = wr_data[PTR_W-1:0];
        else if (bump)  ptr_d = ptr_q + 1'b1;
        else            ptr_d = ptr_q;

        snap     = do_rs | wrap;
        store_we = data_wr & ~in_time;
        rd_en    = do_rr;
        tk_load  = data_wr & in_time;
        tk_field = ptr_q[FIELD_W-1:0];
        tk_data  = wr_data;
    end

    assign ptr = ptr_q;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R3
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_take |=> ptr_q == $past(wr_data[PTR_W-1:0])); // R2
    AST_TK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        tk_load |-> !store_we && !addr_take); // R5
endmodule

// File: rtl/rtc_ctrl_filter.sv
module rtc_ctrl_filter
    import rtc_reg_pkg::*;
(
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [BYTE_W-1:0] cur_val,
    output logic [BYTE_W-1:0] next_val
);
    logic [BYTE_W-1:0] stop_sel;

    always_comb begin
        stop_sel = '0;
        stop_sel[STOP_BIT] = 1'b1;
        // zero the forced bits; stop flag may only fall
        next_val = (wr_byte & CTRL_KEEP_MASK & ~stop_sel)
                 | (wr_byte & cur_val & stop_sel);
    end
endmodule

// File: rtl/rtc_reg_store.sv
module rtc_reg_store
    import rtc_reg_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          snap,
    input  logic [TIME_REGS*BYTE_W-1:0]   live_time,
    input  logic                          we,
    input  logic [PTR_W-1:0]              addr,
    input  logic [BYTE_W-1:0]             wdata,
    input  logic                          rd_en,
    output logic [BYTE_W-1:0]             rd_data,
    output logic                          rd_valid,
    output logic [BYTE_W-1:0]             ctrl_val
);
    localparam int DEPTH = 1 << PTR_W;

    logic [BYTE_W-1:0] ent_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [BYTE_W-1:0] ent_q;
        if (i < TIME_REGS) begin : g_shadow
            always_ff @(posedge clk) begin
                if (!rst_n)    ent_q <= '0;
                else if (snap) ent_q <= live_time[i*BYTE_W +: BYTE_W];
            end
        end else begin : g_ram
            always_ff @(posedge clk) begin
                if (!rst_n)                           ent_q <= '0;
                else if (we && addr == PTR_W'(i))     ent_q <= wdata;
            end
        end
        assign ent_w[i] = ent_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= ent_w[addr];
        end
    end

    assign ctrl_val = ent_w[CTRL_ADDR];

    AST_CTRL_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_w[CTRL_ADDR] & ~CTRL_KEEP_MASK) == '0); // R8
    AST_STOP_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !ent_w[CTRL_ADDR][STOP_BIT] |=> !ent_w[CTRL_ADDR][STOP_BIT]); // R9
    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> ent_w[0] == $past(live_time[BYTE_W-1:0])); // R6
    AST_RD_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R11
    AST_RD_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R11
endmodule

// File: rtl/rtc_regfile_engine.sv
module rtc_regfile_engine
    import rtc_reg_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_wr_start,
    input  logic         ev_rd_start,
    input  logic         ev_wr_byte,
    input  logic [7:0]   wr_data,
    input  logic         ev_rd_req,
    input  logic [55:0]  live_time,
    output logic [7:0]   rd_data,
    output logic         rd_valid,
    output logic         tk_load,
    output logic [2:0]   tk_field,
    output logic [7:0]   tk_data
);
    logic [PTR_W-1:0]  ptr;
    logic              snap, store_we, rd_en;
    logic [BYTE_W-1:0] ctrl_val, ctrl_next, store_data;

    rtc_xfer_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_wr_start (ev_wr_start),
        .ev_rd_start (ev_rd_start),
        .ev_wr_byte  (ev_wr_byte),
        .wr_data     (wr_data),
        .ev_rd_req   (ev_rd_req),
        .ptr         (ptr),
        .snap        (snap),
        .store_we    (store_we),
        .rd_en       (rd_en),
        .tk_load     (tk_load),
        .tk_field    (tk_field),
        .tk_data     (tk_data)
    );

    rtc_ctrl_filter u_ctrl (
        .wr_byte  (wr_data),
        .cur_val  (ctrl_val),
        .next_val (ctrl_next)
    );

    assign store_data = (ptr == PTR_W'(CTRL_ADDR)) ? ctrl_next : wr_data;

    rtc_reg_store #(.PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap      (snap),
        .live_time (live_time),
        .we        (store_we),
        .addr      (ptr),
        .wdata     (store_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .ctrl_val  (ctrl_val)
    );
endmodule

// File: tb/test_rtc_regfile_engine.sv
module test_rtc_regfile_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_wr_start = 1'b0, ev_rd_start = 1'b0, ev_wr_byte = 1'b0, ev_rd_req = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [55:0] live_time = '0;
    logic [7:0]  rd_data, tk_data;
    logic        rd_valid, tk_load;
    logic [2:0]  tk_field;
    int n_total = 0, n_fail = 0;

    always #2 clk = ~clk;

    rtc_regfile_engine i_rtc_regfile_engine (
        .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
        .ev_wr_byte(ev_wr_byte), .wr_data(wr_data), .ev_rd_req(ev_rd_req),
        .live_time(live_time), .rd_data(rd_data), .rd_valid(rd_valid),
        .tk_load(tk_load), .tk_field(tk_field), .tk_data(tk_data)
    );

    function automatic logic [55:0] mk_live(input logic [7:0] base);
        logic [55:0] v;
        for (int i = 0; i < 7; i++) v[i*8 +: 8] = base + 8'(i);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wstart();
        @(negedge clk); ev_wr_start = 1'b1;
        @(negedge clk); ev_wr_start = 1'b0;
    endtask

    task automatic rstart();
        @(negedge clk); ev_rd_start = 1'b1;
        @(negedge clk); ev_rd_start = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ld, output logic [2:0] f,
                         output logic [7:0] d);
        @(negedge clk); ev_wr_byte = 1'b1; wr_data = b;
        #1; ld = tk_load; f = tk_field; d = tk_data;
        @(negedge clk); ev_wr_byte = 1'b0;
    endtask

    task automatic rreq(output logic [7:0] d, output logic v);
        @(negedge clk); ev_rd_req = 1'b1;
        @(negedge clk); ev_rd_req = 1'b0; d = rd_data; v = rd_valid;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic ld; logic [2:0] f; logic [7:0] d;
        wstart();
        wbyte(a, ld, f, d);
        chk(ld == 1'b0, "R2 address byte no load", ld, 0);
    endtask

    task automatic t_reset();
        logic ld; logic [2:0] f; logic [7:0] d; logic v;
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        wbyte(8'h45, ld, f, d);
        chk(ld && f == 3'd0 && d == 8'h45, "R1 byte as data at entry 0", {ld, f, d}, {1'b1, 3'd0, 8'h45});
        rreq(d, v);
        chk(v && d == 8'h00, "R1 entry 1 zero", {v, d}, {1'b1, 8'h00});
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11 rd_valid falls", rd_valid, 0);
    endtask

    task automatic t_ram();
        logic ld; logic [2:0] f; logic [7:0] d; logic v;
        set_ptr(8'hC8);
        wbyte(8'h11, ld, f, d);
        wbyte(8'h22, ld, f, d);
        set_ptr(8'h08);
        rreq(d, v); chk(d == 8'h11, "R4 entry 8 / R2 mask", d, 8'h11);
        rreq(d, v); chk(d == 8'h22, "R3 auto increment", d, 8'h22);
    endtask

    task automatic t_time_write();
        logic ld; logic [2:0] f; logic [7:0] d; logic v;
        set_ptr(8'h02);
        wbyte(8'h59, ld, f, d);
        chk(ld && f == 3'd2 && d == 8'h59, "R5 timekeeper load", {ld, f, d}, {1'b1, 3'd2, 8'h59});
        @(negedge clk);
        chk(tk_load == 1'b0, "R5 load one cycle", tk_load, 0);
        set_ptr(8'h02);
        rreq(d, v); chk(d == 8'h00, "R5 shadow unchanged", d, 0);
    endtask

    task automatic t_snapshot();
        logic [7:0] d; logic v;
        live_time = mk_live(8'h10);
        rstart();
        set_ptr(8'h00);
        for (int i = 0; i < 7; i++) begin
            rreq(d, v);
            chk(d == 8'(8'h10 + i), "R6 read start snapshot", d, 8'h10 + i);
        end
    endtask

    task automatic t_ctrl();
        logic ld; logic [2:0] f; logic [7:0] d; logic v;
        set_ptr(8'h07);
        wbyte(8'hFF, ld, f, d);
        chk(ld == 1'b0, "R8 control not forwarded", ld, 0);
        set_ptr(8'h07);
        rreq(d, v); chk(d == 8'h93, "R8 R9 control mask", d, 8'h93);
        set_ptr(8'h07);
        wbyte(8'h00, ld, f, d);
        set_ptr(8'h07);
        rreq(d, v); chk(d == 8'h00, "R9 write zero", d, 0);
    endtask

    task automatic t_wrap();
        logic ld; logic [2:0] f; logic [7:0] d; logic v;
        live_time = mk_live(8'h30);
        set_ptr(8'h3F);
        wbyte(8'hA5, ld, f, d);
        live_time = mk_live(8'h50);
        set_ptr(8'h3F);
        rreq(d, v); chk(d == 8'hA5, "R7 entry 63 old value", d, 8'hA5);
        rreq(d, v); chk(d == 8'h50, "R7 wrap snapshot", d, 8'h50);
        rreq(d, v); chk(d == 8'h51, "R7 wrap snapshot entry 1", d, 8'h51);
    endtask

    task automatic t_priority();
        logic ld; logic [2:0] f; logic [7:0] d; logic v;
        @(negedge clk); ev_wr_start = 1'b1; ev_rd_req = 1'b1;
        @(negedge clk); ev_wr_start = 1'b0; ev_rd_req = 1'b0;
        chk(rd_valid == 1'b0, "R10 read request loses to write start", rd_valid, 0);
        wbyte(8'h09, ld, f, d);
        chk(ld == 1'b0, "R10 next byte is address", ld, 0);
        rreq(d, v); chk(d == 8'h22, "R10 pointer from address", d, 8'h22);
        live_time = mk_live(8'h70);
        @(negedge clk); ev_rd_start = 1'b1; ev_wr_byte = 1'b1; wr_data = 8'h77;
        #1; chk(tk_load == 1'b0, "R10 byte ignored no load", tk_load, 0);
        @(negedge clk); ev_rd_start = 1'b0; ev_wr_byte = 1'b0;
        set_ptr(8'h0A);
        rreq(d, v); chk(d == 8'h00, "R10 byte ignored entry 10", d, 0);
        set_ptr(8'h00);
        rreq(d, v); chk(d == 8'h70, "R10 read start acted", d, 8'h70);
    endtask

    initial begin
        #(200000 * 4);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ram();
        t_time_write();
        t_snapshot();
        t_ctrl();
        t_wrap();
        t_priority();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule